// File: doc/BRIEF.md
# Dual Interval Timers with Clock Tick Counter

This block holds two identical programmable interval timers and a free-running clock tick counter behind one small register port. After each retired instruction the CPU presents how many cycles that instruction took. Every enabled timer adds this count to a prescaler accumulator. Each time the accumulator crosses the timer's selected limit, the limit is taken off and the leftover carries forward. Each crossing advances the timer's 8-bit count. When the count reaches its programmed compare value, the count returns to zero and the timer's interrupt is raised.

A separate tick input advances the low six bits of an 8-bit clock register, leaves its two high bits alone, and raises a clock interrupt. All three interrupts stay raised until software clears them by writing ones to the interrupt register. The CPU and the interrupt controller sit outside this block.

Top module: `ivt_dual_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and all three interrupt outputs are low.
- R2: Register map (3-bit address): timer 0 control/compare/count at 0/1/2, timer 1 control/compare/count at 3/4/5, clock register at 6, interrupt register at 7. A control register holds enable in bit 0 and limit select in bits 3:1. Bits 7:4 are ignored on write and read as 0. Reads are combinational from the address.
- R3: Limit select 0 gives a limit of 2. A select value k from 1 to 7 gives a limit of 1024·2^(k-1), so the largest is 65536.
- R4: When a cycle-count strobe arrives, an enabled timer adds the count to its accumulator. On any cycle where the accumulator plus that addition is at least the limit, the limit is subtracted and the count advances by one. This is one subtraction per clock, so any excess drains over the following clocks.
- R5: When an advance would make the count greater than or equal to the compare value, the count becomes 0 instead and the timer's interrupt is raised. A compare value of 0 therefore raises the interrupt on every advance.
- R6: A disabled timer ignores the cycle-count strobe, and its accumulator and count are held.
- R7: Writing a timer's control register clears its accumulator. That timer makes no advance in the same cycle.
- R8: Each tick increments bits 5:0 of the clock register, wrapping from 63 to 0. Bits 7:6 are kept, and the clock interrupt is raised.
- R9: The interrupt register reports bit 0 for timer 0, bit 1 for timer 1 and bit 2 for the clock. Writing a 1 to a bit clears it and writing a 0 leaves it. A new event in the same cycle as a clear leaves the bit set.
- R10: The two timers are independent: activity on one never changes the other's count, compare value or interrupt.
- R11: A register write to a count or to the clock register takes priority over an advance or tick in the same cycle. The interrupt from that event is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| step_valid | input | 1 | Cycle-count strobe, one per retired instruction |
| step_cycles | input | 8 | Cycles taken by that instruction |
| tick | input | 1 | Clock tick pulse |
| irq_t0 | output | 1 | Timer 0 interrupt, sticky |
| irq_t1 | output | 1 | Timer 1 interrupt, sticky |
| irq_clk | output | 1 | Clock tick interrupt, sticky |

## Verification
The assertions rely on each timer's accumulator staying well inside its width. They take for granted that a cycle count never exceeds the smallest limit among the enabled timers, apart from isolated bursts that are given idle clocks to drain. The random stimulus enforces this bound. Before each strobe it reads the enable and select state from its own model and picks the count from zero up to that bound. The single deliberate over-limit burst is followed by enough idle cycles for the backlog to clear.

// File: rtl/ivt_pkg.sv
// Package: shared widths, register offsets and the limit function for the
// dual interval timer block. Assumes exactly two timers share the map.
package ivt_pkg;
    localparam int DATA_W         = 8;
    localparam int CYC_W          = 8;
    localparam int SEL_W          = 3;
    localparam int BASE_SHIFT     = 9;
    localparam int LIMIT_W        = BASE_SHIFT + (1 << SEL_W);
    localparam int ACC_W          = LIMIT_W + 1;
    localparam int CLK_LOW_W      = 6;
    localparam int N_TIMERS       = 2;
    localparam int REGS_PER_TIMER = 3;
    localparam int ADDR_W         = 3;
    localparam int IRQ_W          = N_TIMERS + 1;

    localparam int OFS_CTRL = 0;
    localparam int OFS_CMP  = 1;
    localparam int OFS_DATA = 2;
    localparam logic [ADDR_W-1:0] ADDR_CLOCK = ADDR_W'(N_TIMERS * REGS_PER_TIMER);
    localparam logic [ADDR_W-1:0] ADDR_IRQ   = ADDR_W'(N_TIMERS * REGS_PER_TIMER + 1);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
    } ctrl_t;

    // Limit chosen by a select code: 2 for code 0, else 2^(BASE_SHIFT+code).
    function automatic logic [LIMIT_W-1:0] limit_of(input logic [SEL_W-1:0] sel);
        if (sel == '0)
            return LIMIT_W'(2);
        return LIMIT_W'(1) << (BASE_SHIFT + 32'(sel));
    endfunction
endpackage

// File: rtl/ivt_prescaler.sv
// Prescaler accumulator: adds a cycle count per strobe while enabled and
// takes off one limit per clock when it reaches the limit, emitting a bump.
// Assumes the caller keeps counts small enough that the sum fits ACC_W.
module ivt_prescaler
    import ivt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             clear,
    input  logic             step_valid,
    input  logic [CYC_W-1:0] step_cycles,
    output logic             bump
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] lim;
    logic             over;

    // Next accumulator value and whether a limit is crossed this cycle.
    always_comb begin
        lim  = ACC_W'(limit_of(sel));
        sum  = acc_q + ((en && step_valid) ? ACC_W'(step_cycles) : '0);
        over = en && (sum >= lim);
        bump = over && !clear;
        if (clear)
            acc_d = '0;
        else if (over)
            acc_d = sum - lim;
        else if (en)
            acc_d = sum;
        else
            acc_d = acc_q;
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end
endmodule

// File: rtl/ivt_counter.sv
// Count register with compare-and-clear: advances on a bump, returns to 0
// and fires when the advanced value reaches the compare value. Software
// writes take priority over the advance; the fire pulse is still produced.
module ivt_counter
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bump,
    input  logic [DATA_W-1:0] cmp,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count,
    output logic              fire
);
    logic [DATA_W:0]   nxt;
    logic [DATA_W-1:0] count_d;

    // Advance, compare with one extra bit so 255+1 compares correctly.
    always_comb begin
        nxt  = {1'b0, count} + (DATA_W+1)'(1);
        fire = bump && (nxt >= {1'b0, cmp});
        if (wr)
            count_d = wdata;
        else if (fire)
            count_d = '0;
        else if (bump)
            count_d = nxt[DATA_W-1:0];
        else
            count_d = count;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else
            count <= count_d;
    end
endmodule

// File: rtl/ivt_timer.sv
// One interval timer: control and compare registers, a prescaler and a
// compare-and-clear counter. Enable and select in effect are the values held
// before a same-cycle control write; that write also clears the accumulator.
module ivt_timer
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              cmp_wr,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step_valid,
    input  logic [CYC_W-1:0]  step_cycles,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic [DATA_W-1:0] count,
    output logic              fire
);
    logic bump;

    // Control and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= ctrl_t'(wdata[SEL_W:0]);
            if (cmp_wr)
                cmp_q <= wdata;
        end
    end

    ivt_prescaler u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctrl_q.en),
        .sel         (ctrl_q.sel),
        .clear       (ctrl_wr),
        .step_valid  (step_valid),
        .step_cycles (step_cycles),
        .bump        (bump)
    );

    ivt_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (bump),
        .cmp   (cmp_q),
        .wr    (data_wr),
        .wdata (wdata),
        .count (count),
        .fire  (fire)
    );
endmodule

// File: rtl/ivt_clock_tick.sv
// Clock tick register: the low CLK_LOW_W bits count ticks and wrap, the
// upper bits only change on a software write, which beats a same-cycle tick.
module ivt_clock_tick
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic [DATA_W-1:0] value
);
    logic [CLK_LOW_W-1:0] low_inc;

    // Wrapping increment of the low field.
    always_comb low_inc = value[CLK_LOW_W-1:0] + CLK_LOW_W'(1);

    // Clock register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (wr)
            value <= wdata;
        else if (tick)
            value <= {value[DATA_W-1:CLK_LOW_W], low_inc};
    end
endmodule

// File: rtl/ivt_irq_bank.sv
// Sticky interrupt flags: set by events, cleared by write-one-to-clear;
// a set in the same cycle as a clear wins.
module ivt_irq_bank #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flags
);
    // Flag register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~clr) | set;
    end
endmodule

// File: rtl/ivt_dual_timer.sv
// Top: two interval timers, a clock tick register and sticky interrupts
// behind a flat 3-bit register port. Assumes the CPU supplies one strobe
// per retired instruction with that instruction's cycle count.
module ivt_dual_timer
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              step_valid,
    input  logic [CYC_W-1:0]  step_cycles,
    input  logic              tick,
    output logic              irq_t0,
    output logic              irq_t1,
    output logic              irq_clk
);
    ctrl_t               tmr_ctrl [N_TIMERS];
    logic [DATA_W-1:0]   tmr_cmp  [N_TIMERS];
    logic [DATA_W-1:0]   tmr_data [N_TIMERS];
    logic [N_TIMERS-1:0] tmr_fire;
    logic [N_TIMERS-1:0] ctrl_wr;
    logic [N_TIMERS-1:0] cmp_wr;
    logic [N_TIMERS-1:0] data_wr;
    logic [DATA_W-1:0]   tick_val;
    logic                tick_wr;
    logic [IRQ_W-1:0]    irq_set;
    logic [IRQ_W-1:0]    irq_clr;
    logic [IRQ_W-1:0]    irq_q;

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
        localparam int BASE = i * REGS_PER_TIMER;

        // Per-timer write decode.
        always_comb begin
            ctrl_wr[i] = reg_wr && (reg_addr == ADDR_W'(BASE + OFS_CTRL));
            cmp_wr[i]  = reg_wr && (reg_addr == ADDR_W'(BASE + OFS_CMP));
            data_wr[i] = reg_wr && (reg_addr == ADDR_W'(BASE + OFS_DATA));
        end

        ivt_timer u_tmr (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctrl_wr     (ctrl_wr[i]),
            .cmp_wr      (cmp_wr[i]),
            .data_wr     (data_wr[i]),
            .wdata       (reg_wdata),
            .step_valid  (step_valid),
            .step_cycles (step_cycles),
            .ctrl_q      (tmr_ctrl[i]),
            .cmp_q       (tmr_cmp[i]),
            .count       (tmr_data[i]),
            .fire        (tmr_fire[i])
        );
    end

    // Clock register and interrupt register write decode.
    always_comb begin
        tick_wr = reg_wr && (reg_addr == ADDR_CLOCK);
        irq_clr = (reg_wr && (reg_addr == ADDR_IRQ)) ? reg_wdata[IRQ_W-1:0] : '0;
        irq_set = {tick, tmr_fire};
    end

    ivt_clock_tick u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (tick_wr),
        .wdata (reg_wdata),
        .tick  (tick),
        .value (tick_val)
    );

    ivt_irq_bank #(.W(IRQ_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .clr   (irq_clr),
        .flags (irq_q)
    );

    // Combinational read mux over the register map.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_TIMERS; i++) begin
            if (reg_addr == ADDR_W'(i * REGS_PER_TIMER + OFS_CTRL))
                reg_rdata = {{(DATA_W-SEL_W-1){1'b0}}, tmr_ctrl[i]};
            if (reg_addr == ADDR_W'(i * REGS_PER_TIMER + OFS_CMP))
                reg_rdata = tmr_cmp[i];
            if (reg_addr == ADDR_W'(i * REGS_PER_TIMER + OFS_DATA))
                reg_rdata = tmr_data[i];
        end
        if (reg_addr == ADDR_CLOCK)
            reg_rdata = tick_val;
        if (reg_addr == ADDR_IRQ)
            reg_rdata = {{(DATA_W-IRQ_W){1'b0}}, irq_q};
    end

    // Interrupt outputs.
    always_comb begin
        irq_t0  = irq_q[0];
        irq_t1  = irq_q[1];
        irq_clk = irq_q[IRQ_W-1];
    end
endmodule

// File: rtl/ivt_dual_timer_chk.sv
// Checker for ivt_dual_timer, attached by bind below. Observes ports plus
// the clock register, timer 0 count and timer 0 enable.
module ivt_dual_timer_chk
    import ivt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              tick,
    input logic              irq_t0,
    input logic              irq_clk,
    input logic [DATA_W-1:0] tick_val,
    input logic [DATA_W-1:0] data0,
    input logic              en0
);
    logic clk_wr;
    logic clr_t0;

    always_comb begin
        clk_wr = reg_wr && (reg_addr == ADDR_CLOCK);
        clr_t0 = reg_wr && (reg_addr == ADDR_IRQ) && reg_wdata[0];
    end

    AST_TICK_LOW_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clk_wr) |=> tick_val[CLK_LOW_W-1:0] == $past(tick_val[CLK_LOW_W-1:0]) + CLK_LOW_W'(1)); // R8
    AST_TICK_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_wr) |=> tick_val[DATA_W-1:CLK_LOW_W] == $past(tick_val[DATA_W-1:CLK_LOW_W])); // R8
    AST_TICK_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> irq_clk); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_t0 && !clr_t0) |=> irq_t0); // R9
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en0 && !reg_wr) |=> $stable(data0)); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr) |=> (data0 == $past(data0)) || (data0 == $past(data0) + DATA_W'(1)) || (data0 == '0)); // R4
    AST_CLEAR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((!reg_wr && data0 != '0) ##1 (data0 == '0)) |-> irq_t0); // R5
endmodule

bind ivt_dual_timer ivt_dual_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tick      (tick),
    .irq_t0    (irq_t0),
    .irq_clk   (irq_clk),
    .tick_val  (tick_val),
    .data0     (tmr_data[0]),
    .en0       (tmr_ctrl[0].en)
);

// File: tb/ivt_dual_timer_tb.sv
`timescale 1ns/1ps
module ivt_dual_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    wire  [7:0] reg_rdata;
    logic       step_valid = 1'b0;
    logic [7:0] step_cycles = '0;
    logic       tick = 1'b0;
    wire        irq_t0, irq_t1, irq_clk;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Reference model state.
    int m_acc [2];
    int m_data [2];
    int m_cmp [2];
    int m_en [2];
    int m_sel [2];
    int m_clk;
    int m_irq [3];

    always #2.5 clk = ~clk;

    ivt_dual_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .step_valid  (step_valid),
        .step_cycles (step_cycles),
        .tick        (tick),
        .irq_t0      (irq_t0),
        .irq_t1      (irq_t1),
        .irq_clk     (irq_clk)
    );

    function automatic int lim_of(int s);
        return (s == 0) ? 2 : (1024 << (s - 1));
    endfunction

    function automatic int model_read(int a);
        case (a)
            0: return m_en[0] + 2 * m_sel[0];
            1: return m_cmp[0];
            2: return m_data[0];
            3: return m_en[1] + 2 * m_sel[1];
            4: return m_cmp[1];
            5: return m_data[1];
            6: return m_clk;
            default: return m_irq[0] + 2 * m_irq[1] + 4 * m_irq[2];
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            0, 3: return "R2 control readback";
            1, 4: return "R2 compare readback";
            2, 5: return "R4 count";
            6: return "R8 clock register";
            default: return "R9 interrupt register";
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock of the reference model, from the inputs held this cycle.
    task automatic model_step();
        int fired [3];
        int sum;
        int bump;
        for (int i = 0; i < 2; i++) begin
            int base = 3 * i;
            fired[i] = 0;
            bump = 0;
            if (reg_wr && reg_addr == base) begin
                m_en[i]  = int'(reg_wdata[0]);
                m_sel[i] = int'(reg_wdata[3:1]);
                m_acc[i] = 0;
            end else if (m_en[i] != 0) begin
                sum = m_acc[i] + (step_valid ? int'(step_cycles) : 0);
                if (sum >= lim_of(m_sel[i])) begin
                    m_acc[i] = sum - lim_of(m_sel[i]);
                    bump = 1;
                end else begin
                    m_acc[i] = sum;
                end
            end
            if (bump != 0) begin
                if (m_data[i] + 1 >= m_cmp[i]) begin
                    m_data[i] = 0;
                    fired[i] = 1;
                end else begin
                    m_data[i] = m_data[i] + 1;
                end
            end
            if (reg_wr && reg_addr == base + 1) m_cmp[i] = int'(reg_wdata);
            if (reg_wr && reg_addr == base + 2) m_data[i] = int'(reg_wdata);
        end
        fired[2] = int'(tick);
        if (reg_wr && reg_addr == 6)
            m_clk = int'(reg_wdata);
        else if (tick)
            m_clk = (m_clk / 64) * 64 + ((m_clk + 1) % 64);
        for (int k = 0; k < 3; k++) begin
            if (reg_wr && reg_addr == 7 && reg_wdata[k]) m_irq[k] = 0;
            if (fired[k] != 0) m_irq[k] = 1;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_acc[i] = 0; m_data[i] = 0; m_cmp[i] = 0; m_en[i] = 0; m_sel[i] = 0;
            end
            m_clk = 0;
            for (int k = 0; k < 3; k++) m_irq[k] = 0;
        end else begin
            model_step();
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            #1;
            chk(tag_of(int'(reg_addr)), int'(reg_rdata), model_read(int'(reg_addr)));
            chk("R9 interrupt outputs", int'({irq_clk, irq_t1, irq_t0}),
                m_irq[0] + 2 * m_irq[1] + 4 * m_irq[2]);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic step(int n);
        @(negedge clk);
        step_valid = 1'b1; step_cycles = 8'(n);
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic expect_reg(int a, int exp, string tag);
        @(negedge clk);
        reg_addr = 3'(a);
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and interrupt.
        for (int a = 0; a < 8; a++) expect_reg(a, 0, "R1 register after reset");
        chk("R1 interrupts after reset", int'({irq_clk, irq_t1, irq_t0}), 0);

        // R2: control format, ignored upper bits, compare readback.
        wr(0, 8'h0B);
        expect_reg(0, 8'h0B, "R2 control enable and select");
        wr(0, 8'hF0);
        expect_reg(0, 8'h00, "R2 upper control bits ignored");
        wr(3, 8'h0E);
        expect_reg(3, 8'h0E, "R2 timer 1 control");
        wr(1, 8'h37);
        expect_reg(1, 8'h37, "R2 compare register");

        // R4: over-limit burst drains one limit per clock, leftover kept.
        wr(3, 8'h00);
        wr(1, 200);
        wr(2, 0);
        wr(0, 8'h01);
        step(9);
        repeat (6) @(negedge clk);
        expect_reg(2, 4, "R4 burst drains to four advances");
        step(1);
        repeat (2) @(negedge clk);
        expect_reg(2, 5, "R4 leftover carried into next step");

        // R3: select 1 gives a limit of 1024.
        wr(0, 8'h03);
        wr(2, 0);
        repeat (5) step(200);
        expect_reg(2, 0, "R3 below 1024 no advance");
        step(200);
        expect_reg(2, 1, "R3 advance at 1024");

        // R7: control write clears the leftover 176.
        wr(0, 8'h03);
        repeat (5) step(200);
        expect_reg(2, 1, "R7 accumulator cleared by control write");
        step(24);
        expect_reg(2, 2, "R7 advance after exactly 1024");

        // R5 and R10: timer 1 reaches compare 3, timer 0 untouched.
        wr(4, 3);
        wr(5, 0);
        wr(3, 8'h01);
        repeat (3) step(2);
        expect_reg(5, 0, "R5 count cleared at compare");
        chk("R5 timer 1 interrupt", int'(irq_t1), 1);
        chk("R10 timer 0 interrupt unaffected", int'(irq_t0), 0);
        expect_reg(2, 2, "R10 timer 0 count unaffected");

        // R9: write-one-to-clear, per bit.
        wr(7, 8'h01);
        chk("R9 other bit kept on clear", int'(irq_t1), 1);
        wr(7, 8'h02);
        chk("R9 bit cleared by writing one", int'(irq_t1), 0);

        // R6: disabled timer ignores steps.
        wr(3, 8'h00);
        repeat (3) step(2);
        expect_reg(5, 0, "R6 disabled count held");
        chk("R6 disabled no interrupt", int'(irq_t1), 0);

        // R8: low field wraps, top bits kept.
        wr(6, 8'hBE);
        pulse_tick();
        expect_reg(6, 8'hBF, "R8 tick increments low field");
        pulse_tick();
        expect_reg(6, 8'h80, "R8 wrap keeps top bits");
        chk("R8 clock interrupt", int'(irq_clk), 1);

        // R9: event beats a same-cycle clear.
        @(negedge clk);
        tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd7; reg_wdata = 8'h04;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        chk("R9 event wins over clear", int'(irq_clk), 1);
        wr(7, 8'h04);
        chk("R9 clock interrupt cleared", int'(irq_clk), 0);

        // R11: software write beats tick and advance in the same cycle.
        @(negedge clk);
        tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h45;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        expect_reg(6, 8'h45, "R11 clock write beats tick");
        chk("R11 tick interrupt still raised", int'(irq_clk), 1);
        wr(0, 8'h03);
        repeat (4) step(255);
        @(negedge clk);
        step_valid = 1'b1; step_cycles = 8'd4;
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h10;
        @(negedge clk);
        step_valid = 1'b0; reg_wr = 1'b0;
        expect_reg(2, 8'h10, "R11 count write beats advance");

        // R5: compare value 0 fires on every advance.
        wr(4, 0);
        wr(3, 8'h01);
        step(2);
        expect_reg(5, 0, "R5 compare zero keeps count at 0");
        chk("R5 compare zero interrupt", int'(irq_t1), 1);

        // Random phase, step counts kept within the smallest enabled limit.
        for (int c = 0; c < 4000; c++) begin
            int maxs;
            @(negedge clk);
            maxs = 255;
            for (int i = 0; i < 2; i++)
                if (m_en[i] != 0 && lim_of(m_sel[i]) < maxs) maxs = lim_of(m_sel[i]);
            reg_wr      = ($urandom % 8) == 0;
            reg_addr    = 3'($urandom % 8);
            reg_wdata   = 8'($urandom);
            step_valid  = ($urandom % 3) == 0;
            step_cycles = 8'($urandom % (maxs + 1));
            tick        = ($urandom % 5) == 0;
        end
        @(negedge clk);
        reg_wr = 1'b0; step_valid = 1'b0; tick = 1'b0;
        repeat (4) @(negedge clk);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule